// File: doc/BRIEF.md
# Multi-Ring Transmit Doorbell Register File

This block is the register-side front end of an Ethernet transmit DMA that can serve up to three descriptor rings. Software programs a start address and rings a doorbell for each ring over a simple 32-bit register bus addressed by word index (byte offset shifted right by two). The block keeps one current-descriptor pointer per ring and hands one ring at a time to an external descriptor walker. It also holds a global enable bit, a write-one-to-clear event register and an interrupt mask.

The walker sees a request, the ring number and that ring's current pointer. It answers with a one-cycle done pulse that carries the pointer at which the ring stopped and two event flags. A build-time parameter sets the number of rings from 1 to 3. Registers that belong to rings beyond that count read as zero, and writes to them change nothing.

Top module: `txr_doorbell_regs`

## Requirements
- R1: Word indices are: event 1, mask 2, control 9 (enable at bit 1), ring 0 start 97, ring 1 start 89, ring 2 start 92, ring 0 doorbell 5, ring 1 doorbell 121, ring 2 doorbell 123; a start-address write stores the data with bits 2:0 forced to zero and reads back that value; unmapped indices read zero.
- R2: A start-address write also loads that ring's current pointer with the masked value, which appears on walkPtr when the ring is served.
- R3: With RING_COUNT=1, writes to the ring 1 and ring 2 start and doorbell registers change no state, and reads of them return zero.
- R4: A doorbell write while enable is clear has no effect; while enable is set it marks the ring pending, and the doorbell reads back with bit 24 set until the ring's done pulse.
- R5: A control write with enable clear drops every pending doorbell and the active request, and reloads every ring pointer from its start address.
- R6: Pending rings are granted one at a time, lowest ring number first; walkRing stays below RING_COUNT.
- R7: A walkDone while a request is active ends the request on the next edge, loads the active ring's pointer from walkNextPtr and clears its doorbell, unless that doorbell is written in the same cycle.
- R8: Event bits: ring 0 frame 27 and buffer 26, ring 1 frame 3 and buffer 2, ring 2 frame 7 and buffer 6. They are set by walkFrameEvt and walkBufEvt with walkDone, and cleared by writing one to them; when a set and a clear coincide, the set wins.
- R9: irq is high exactly when some event bit and the same mask bit are both set, one cycle after the change.
- R10: Reset clears all pointers, start addresses, doorbells, events, mask and enable; walkReq and irq are low.
- R11: With no ring active, walkReq rises on the second edge after a doorbell write and holds with a stable walkRing until done or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| walkReq | output | 1 | Ring service request to the walker |
| walkRing | output | 2 | Ring being requested |
| walkPtr | output | 32 | Current descriptor pointer of that ring |
| walkDone | input | 1 | Walker finished the active ring |
| walkNextPtr | input | 32 | Pointer where the walker stopped |
| walkBufEvt | input | 1 | Buffer-done event with walkDone |
| walkFrameEvt | input | 1 | Frame-done event with walkDone |
| irq | output | 1 | Masked event interrupt |

## Verification
A corrupted pointer shows on walkPtr the next time that ring is granted, which is two edges after its doorbell when the block is idle. A lost or stuck pending bit shows at once on the doorbell readback, and on the next grant as a wrong or missing walkRing. Wrong event handling shows in the event readback and on irq one edge after the done pulse or mask write. A cycle-level reference model in the bench tracks every register, and its values are compared with busRdData before each edge and with the walker outputs after it.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int MAX_RINGS = 3;
  localparam int IDX_EVENT = 1;
  localparam int IDX_MASK = 2;
  localparam int IDX_CTRL = 9;
  localparam int CTRL_EN_BIT = 1;
  localparam int DOOR_BIT = 24;

  function automatic int startIdx(input int r);
    case (r)
      0: return 97;
      1: return 89;
      default: return 92;
    endcase
  endfunction

  function automatic int doorIdx(input int r);
    case (r)
      0: return 5;
      1: return 121;
      default: return 123;
    endcase
  endfunction

  function automatic int frameBit(input int r);
    case (r)
      0: return 27;
      1: return 3;
      default: return 7;
    endcase
  endfunction

  function automatic int bufBit(input int r);
    case (r)
      0: return 26;
      1: return 2;
      default: return 6;
    endcase
  endfunction

  function automatic logic [MAX_RINGS-1:0] liveMask(input int n);
    logic [MAX_RINGS-1:0] m;
    m = '0;
    for (int r = 0; r < MAX_RINGS; r++) if (r < n) m[r] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] eventLive(input int n);
    logic [31:0] m;
    m = '0;
    for (int r = 0; r < MAX_RINGS; r++) begin
      if (r < n) begin
        m[frameBit(r)] = 1'b1;
        m[bufBit(r)] = 1'b1;
      end
    end
    return m;
  endfunction

  typedef struct packed {
    logic [MAX_RINGS-1:0] startWr;
    logic rewind;
    logic maskWr;
    logic evtClr;
    logic [MAX_RINGS-1:0] doneRing;
    logic bufSet;
    logic frameSet;
  } txr_strobe_t;
endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int RING_COUNT = 3,
  parameter int ADDR_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 ctrlEnData,
  input  logic                 walkDone,
  input  logic                 walkBufEvt,
  input  logic                 walkFrameEvt,
  output txr_strobe_t          strobes,
  output logic                 ethEn,
  output logic [MAX_RINGS-1:0] pendQ,
  output logic                 activeQ,
  output logic [1:0]           ringQ
);
  localparam logic [MAX_RINGS-1:0] LIVE = liveMask(RING_COUNT);

  logic ctrlWr, ctrlOff, doneHit, grant;
  logic [MAX_RINGS-1:0] doorWr, startWr, doneRing, pendNext;
  logic [1:0] pick;

  assign ctrlWr = busWrEn && (busAddr == ADDR_W'(IDX_CTRL));
  assign ctrlOff = ctrlWr && !ctrlEnData;

  // R3: decode only rings below RING_COUNT
  for (genvar r = 0; r < MAX_RINGS; r++) begin : g_dec
    assign doorWr[r] = LIVE[r] && busWrEn && (busAddr == ADDR_W'(doorIdx(r)));
    assign startWr[r] = LIVE[r] && busWrEn && (busAddr == ADDR_W'(startIdx(r)));
  end

  assign doneHit = walkDone && activeQ;
  assign doneRing = doneHit ? (MAX_RINGS'(1) << ringQ) : '0;
  assign grant = !activeQ && (|pendQ);
  assign pendNext = (pendQ & ~doneRing) | (doorWr & {MAX_RINGS{ethEn}});

  // R6: lowest pending ring wins
  always_comb begin
    pick = 2'd0;
    for (int r = MAX_RINGS - 1; r >= 0; r--) if (pendQ[r]) pick = 2'(r);
  end

  always_comb begin
    strobes.startWr = startWr;
    strobes.rewind = ctrlOff;
    strobes.maskWr = busWrEn && (busAddr == ADDR_W'(IDX_MASK));
    strobes.evtClr = busWrEn && (busAddr == ADDR_W'(IDX_EVENT));
    strobes.doneRing = doneRing;
    strobes.bufSet = walkBufEvt;
    strobes.frameSet = walkFrameEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ethEn <= 1'b0;
      pendQ <= '0;
      activeQ <= 1'b0;
      ringQ <= 2'd0;
    end else begin
      if (ctrlWr) ethEn <= ctrlEnData;
      if (ctrlOff) begin
        pendQ <= '0;
        activeQ <= 1'b0;
      end else begin
        pendQ <= pendNext;
        if (doneHit) begin
          activeQ <= 1'b0;
        end else if (grant) begin
          activeQ <= 1'b1;
          ringQ <= pick;
        end
      end
    end
  end
endmodule

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int RING_COUNT = 3,
  parameter int ADDR_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txr_strobe_t          strobes,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWrData,
  input  logic [31:0]          walkNextPtr,
  input  logic                 ethEn,
  input  logic [MAX_RINGS-1:0] pendQ,
  input  logic [1:0]           ringQ,
  output logic [31:0]          busRdData,
  output logic [31:0]          walkPtr,
  output logic                 irq
);
  localparam logic [MAX_RINGS-1:0] LIVE = liveMask(RING_COUNT);
  localparam logic [31:0] EVT_LIVE = eventLive(RING_COUNT);

  logic [MAX_RINGS-1:0][31:0] startQ, ptrQ;
  logic [31:0] evtQ, maskQ, evtSet, evtClrBits, alignedData;

  assign alignedData = {busWrData[31:3], 3'b000};

  always_comb begin
    evtSet = '0;
    for (int r = 0; r < MAX_RINGS; r++) begin
      if (strobes.doneRing[r]) begin
        if (strobes.frameSet) evtSet[frameBit(r)] = 1'b1;
        if (strobes.bufSet) evtSet[bufBit(r)] = 1'b1;
      end
    end
  end

  assign evtClrBits = strobes.evtClr ? busWrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      ptrQ <= '0;
      evtQ <= '0;
      maskQ <= '0;
    end else begin
      for (int r = 0; r < MAX_RINGS; r++) begin
        if (strobes.startWr[r]) startQ[r] <= alignedData;
        if (strobes.rewind) ptrQ[r] <= startQ[r];
        else if (strobes.startWr[r]) ptrQ[r] <= alignedData;
        else if (strobes.doneRing[r]) ptrQ[r] <= walkNextPtr;
      end
      evtQ <= ((evtQ & ~evtClrBits) | evtSet) & EVT_LIVE;
      if (strobes.maskWr) maskQ <= busWrData;
    end
  end

  always_comb begin
    case (ringQ)
      2'd1: walkPtr = ptrQ[1];
      2'd2: walkPtr = ptrQ[2];
      default: walkPtr = ptrQ[0];
    endcase
  end

  assign irq = |(evtQ & maskQ);

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(IDX_CTRL)) busRdData[CTRL_EN_BIT] = ethEn;
    if (busAddr == ADDR_W'(IDX_EVENT)) busRdData = evtQ;
    if (busAddr == ADDR_W'(IDX_MASK)) busRdData = maskQ;
    for (int r = 0; r < MAX_RINGS; r++) begin
      if (LIVE[r] && busAddr == ADDR_W'(startIdx(r))) busRdData = startQ[r];
      if (LIVE[r] && busAddr == ADDR_W'(doorIdx(r))) busRdData[DOOR_BIT] = pendQ[r];
    end
  end
endmodule

// File: rtl/txr_doorbell_regs.sv
module txr_doorbell_regs
  import txr_pkg::*;
#(
  parameter int RING_COUNT = 3,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              walkReq,
  output logic [1:0]        walkRing,
  output logic [31:0]       walkPtr,
  input  logic              walkDone,
  input  logic [31:0]       walkNextPtr,
  input  logic              walkBufEvt,
  input  logic              walkFrameEvt,
  output logic              irq
);
  txr_strobe_t strobes;
  logic ethEn, activeQ;
  logic [MAX_RINGS-1:0] pendQ;
  logic [1:0] ringQ;

  txr_ctrl #(.RING_COUNT(RING_COUNT), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .ctrlEnData(busWrData[CTRL_EN_BIT]), .walkDone(walkDone),
    .walkBufEvt(walkBufEvt), .walkFrameEvt(walkFrameEvt),
    .strobes(strobes), .ethEn(ethEn), .pendQ(pendQ),
    .activeQ(activeQ), .ringQ(ringQ)
  );

  txr_datapath #(.RING_COUNT(RING_COUNT), .ADDR_W(ADDR_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWrData(busWrData), .walkNextPtr(walkNextPtr), .ethEn(ethEn),
    .pendQ(pendQ), .ringQ(ringQ), .busRdData(busRdData),
    .walkPtr(walkPtr), .irq(irq)
  );

  assign walkReq = activeQ;
  assign walkRing = ringQ;
endmodule

// File: rtl/txr_checker.sv
module txr_checker
  import txr_pkg::*;
#(
  parameter int RING_COUNT = 3,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic              walkReq,
  input logic [1:0]        walkRing,
  input logic              walkDone,
  input logic              irq,
  input logic              ethEn
);
  logic ctrlOff;
  assign ctrlOff = busWrEn && (busAddr == ADDR_W'(IDX_CTRL)) && !busWrData[CTRL_EN_BIT];

  a_r6_ring_in_range: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> (int'(walkRing) < RING_COUNT));

  a_r11_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && !walkDone && !ctrlOff) |=> (walkReq && $stable(walkRing)));

  a_r7_done_releases: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && walkDone) |=> !walkReq);

  a_r5_off_drops: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOff |=> (!walkReq && !ethEn));

  a_r4_no_req_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !ethEn |-> !walkReq);

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!walkReq && !irq));
endmodule

bind txr_doorbell_regs txr_checker #(.RING_COUNT(RING_COUNT), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .walkReq(walkReq), .walkRing(walkRing),
  .walkDone(walkDone), .irq(irq), .ethEn(ethEn)
);

// File: tb/txr_doorbell_regs_test.sv
module txr_doorbell_regs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [8:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic walkDone = 1'b0;
  logic [31:0] walkNextPtr = '0;
  logic walkBufEvt = 1'b0;
  logic walkFrameEvt = 1'b0;
  logic noDone = 1'b0;
  logic [31:0] busRdData, walkPtr, sRdData, sPtr;
  logic walkReq, irq, sReq, sIrq;
  logic [1:0] walkRing, sRing;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txr_doorbell_regs #(.RING_COUNT(3), .ADDR_W(9)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .walkReq(walkReq),
    .walkRing(walkRing), .walkPtr(walkPtr), .walkDone(walkDone),
    .walkNextPtr(walkNextPtr), .walkBufEvt(walkBufEvt),
    .walkFrameEvt(walkFrameEvt), .irq(irq)
  );

  txr_doorbell_regs #(.RING_COUNT(1), .ADDR_W(9)) uutSingle (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(sRdData), .walkReq(sReq),
    .walkRing(sRing), .walkPtr(sPtr), .walkDone(noDone),
    .walkNextPtr(walkNextPtr), .walkBufEvt(walkBufEvt),
    .walkFrameEvt(walkFrameEvt), .irq(sIrq)
  );

  // reference model of the three-ring instance
  logic [31:0] mStart [3];
  logic [31:0] mPtr [3];
  logic [2:0] mPend;
  logic mEn, mAct;
  int mRing;
  logic [31:0] mEvt, mMask;
  logic [31:0] lastRd, lastSRd;

  function automatic int startAt(int r);
    return (r == 0) ? 97 : (r == 1) ? 89 : 92;
  endfunction
  function automatic int doorAt(int r);
    return (r == 0) ? 5 : (r == 1) ? 121 : 123;
  endfunction
  function automatic int frmAt(int r);
    return (r == 0) ? 27 : (r == 1) ? 3 : 7;
  endfunction
  function automatic int bufAt(int r);
    return (r == 0) ? 26 : (r == 1) ? 2 : 6;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] v;
    v = '0;
    if (a == 9) v[1] = mEn;
    if (a == 1) v = mEvt;
    if (a == 2) v = mMask;
    for (int r = 0; r < 3; r++) begin
      if (a == startAt(r)) v = mStart[r];
      if (a == doorAt(r)) v[24] = mPend[r];
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic modelStep();
    logic [31:0] nStart [3];
    logic [31:0] nPtr [3];
    logic [2:0] nPend;
    logic nEn, nAct;
    int nRing;
    logic [31:0] setB, clrB, nMask;
    int a;
    for (int r = 0; r < 3; r++) begin nStart[r] = mStart[r]; nPtr[r] = mPtr[r]; end
    nPend = mPend; nEn = mEn; nAct = mAct; nRing = mRing; nMask = mMask;
    setB = '0; clrB = '0;
    a = int'(busAddr);
    if (walkDone && mAct) begin
      nPtr[mRing] = walkNextPtr;
      nPend[mRing] = 1'b0;
      nAct = 1'b0;
      if (walkFrameEvt) setB[frmAt(mRing)] = 1'b1;
      if (walkBufEvt) setB[bufAt(mRing)] = 1'b1;
    end else if (!mAct && mPend != 0) begin
      nAct = 1'b1;
      nRing = mPend[0] ? 0 : mPend[1] ? 1 : 2;
    end
    if (busWrEn) begin
      if (a == 9) begin
        nEn = busWrData[1];
        if (!busWrData[1]) begin
          nPend = '0; nAct = 1'b0;
          for (int r = 0; r < 3; r++) nPtr[r] = mStart[r];
        end
      end
      if (a == 1) clrB = busWrData;
      if (a == 2) nMask = busWrData;
      for (int r = 0; r < 3; r++) begin
        if (a == startAt(r)) begin
          nStart[r] = {busWrData[31:3], 3'b000};
          nPtr[r] = nStart[r];
        end
        if (a == doorAt(r) && mEn) nPend[r] = 1'b1;
      end
    end
    for (int r = 0; r < 3; r++) begin mStart[r] = nStart[r]; mPtr[r] = nPtr[r]; end
    mPend = nPend; mEn = nEn; mAct = nAct; mRing = nRing; mMask = nMask;
    mEvt = ((mEvt & ~clrB) | setB) & 32'h0C0000CC;
  endtask

  task automatic op(bit wr, int a, logic [31:0] d, bit dn, logic [31:0] nxt, bit be, bit fe);
    busWrEn = wr; busAddr = 9'(a); busWrData = d;
    walkDone = dn; walkNextPtr = nxt; walkBufEvt = be; walkFrameEvt = fe;
    #1;
    lastRd = busRdData;
    lastSRd = sRdData;
    chk("R1 read", busRdData, modelRead(a));
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk("R11 walkReq", 32'(walkReq), 32'(mAct));
    if (mAct) begin
      chk("R6 walkRing", 32'(walkRing), 32'(mRing));
      chk("R2 walkPtr", walkPtr, mPtr[mRing]);
    end
    chk("R9 irq", 32'(irq), 32'(|(mEvt & mMask)));
  endtask

  task automatic wr(int a, logic [31:0] d); op(1, a, d, 0, 0, 0, 0); endtask
  task automatic rd(int a); op(0, a, 0, 0, 0, 0, 0); endtask
  task automatic done(logic [31:0] nxt, bit be, bit fe); op(0, 0, 0, 1, nxt, be, fe); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pick, a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int r = 0; r < 3; r++) begin mStart[r] = '0; mPtr[r] = '0; end
    mPend = '0; mEn = 0; mAct = 0; mRing = 0; mEvt = '0; mMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk("R10 walkReq", 32'(walkReq), 0);
    chk("R10 walkPtr", walkPtr, 0);
    chk("R10 irq", 32'(irq), 0);
    rd(97);
    chk("R10 start0", lastRd, 0);
    // R1 alignment and R3 single-ring drop
    wr(89, 32'h1234567F);
    rd(89);
    chk("R1 start1 aligned", lastRd, 32'h12345678);
    chk("R3 single start1", lastSRd, 0);
    // R4 doorbell while disabled
    wr(5, 32'hFFFFFFFF);
    rd(5);
    chk("R4 door off", lastRd, 0);
    chk("R4 no req", 32'(walkReq), 0);
    wr(9, 32'h2);
    wr(121, 0);
    rd(121);
    chk("R4 door pending", lastRd, 32'h01000000);
    chk("R2 ring1 ptr", walkPtr, 32'h12345678);
    chk("R3 single no req", 32'(sReq), 0);
    rd(121);
    chk("R3 single door1", lastSRd, 0);
    wr(5, 0);
    wr(123, 0);
    done(32'h40, 1, 1);
    rd(121);
    chk("R7 door cleared", lastRd, 0);
    chk("R6 ring0 first", 32'(walkRing), 0);
    rd(1);
    chk("R8 ring1 events", lastRd, 32'h0000000C);
    wr(1, 32'h4);
    rd(1);
    chk("R8 w1c", lastRd, 32'h00000008);
    wr(2, 32'h8);
    chk("R9 irq on", 32'(irq), 1);
    wr(2, 0);
    chk("R9 irq off", 32'(irq), 0);
    // R5 disable rewinds
    wr(9, 0);
    chk("R5 req dropped", 32'(walkReq), 0);
    rd(123);
    chk("R5 door2 cleared", lastRd, 0);
    wr(9, 32'h2);
    wr(121, 0);
    rd(0);
    chk("R5 ptr rewound", walkPtr, 32'h12345678);
    chk("R7 ring1 after rewind", 32'(walkRing), 1);
    done(0, 0, 0);
    // R7 same-cycle doorbell keeps ring pending
    wr(121, 0);
    rd(0);
    op(1, 121, 0, 1, 32'h88, 0, 1);
    rd(121);
    chk("R7 rewrite keeps door", lastRd, 32'h01000000);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      pick = $urandom_range(0, 99);
      d = $urandom();
      if (pick < 20) begin
        rd(int'($urandom_range(0, 511)));
      end else if (pick < 45) begin
        a = doorAt(int'($urandom_range(0, 2)));
        wr(a, d);
      end else if (pick < 55) begin
        a = startAt(int'($urandom_range(0, 2)));
        wr(a, d);
      end else if (pick < 60) begin
        wr(9, ($urandom_range(0, 7) != 0) ? 32'h2 : 32'h0);
      end else if (pick < 65) begin
        wr(1, d);
      end else if (pick < 70) begin
        wr(2, d);
      end else if (pick < 75) begin
        wr(int'($urandom_range(0, 511)), d);
      end else begin
        op(0, int'($urandom_range(0, 127)), 0, walkReq && ($urandom_range(0, 1) == 1),
           d, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      end
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule